// File: doc/BRIEF.md
# Cell Receive Front End

This block sits between a physical-layer device and a cell reassembly stage. It controls the PHY's active-low read enable, samples start-of-cell, cell-available, data and two parity bits on each accepted transfer, and passes each cell on as a stream of transfers. Each delivered transfer carries start and end markers, a parity-error flag and a flag that says whether the cell carries a HEC byte. The bus is 8 or 16 bits wide, chosen by a parameter. A transfer is accepted in every cycle in which the block holds the read enable low.

Static configuration inputs set the behaviour. They can require cell-available together with start-of-cell before a cell starts, and they can park the read enable high while the block waits for a cell. They can drop one extra leading header transfer and shorten cells to 52 bytes with no HEC. They select even or odd parity and, on a 16-bit bus, parity over the whole word or over each byte. If a new start-of-cell is accepted in the middle of a cell, the block flags the abort and counts from the new start.

Top module: `cellrx_front`

## Requirements
- R1: `phy_enb_n` is low (transfers accepted) in every cycle except when the sequencer is waiting between cells with `cfg_idle_off`=1. In that waiting state it stays high until `phy_clav` is seen high, and it is low in the next cycle. The cycle after an end-of-cell transfer is a waiting cycle.
- R2: A cell starts only on an accepted transfer with `phy_soc`=1. When `cfg_gate_soc`=1, `phy_clav` must also be 1 in that cycle. When `cfg_gate_soc`=0, `phy_clav` is not looked at.
- R3: Cell length in transfers is ceil(L/B) plus 1 when `cfg_extra_hdr`=1. L is 52 when `cfg_52`=1 and 53 otherwise, and B is BUS_W/8. `cell_eop` marks the last transfer, counted from the starting transfer (index 0).
- R4: When `cfg_extra_hdr`=1, transfer 0 of each cell is not delivered and `cell_sop` marks transfer 1. Otherwise `cell_sop` marks transfer 0.
- R5: `cell_hec` equals the inverse of `cfg_52` on every delivered transfer.
- R6: On an 8-bit bus the parity of `phy_data` together with `phy_par[1]` is checked, and `phy_par[0]` and `cfg_par16` are ignored. The XOR of the data bits and the parity bit must be 1 when `cfg_even_par`=0 (odd) and 0 when `cfg_even_par`=1. `cell_perr`=1 marks a mismatch.
- R7: On a 16-bit bus with `cfg_par16`=1, the parity over all 16 data bits is checked against `phy_par[1]`.
- R8: On a 16-bit bus with `cfg_par16`=0, bits 7:0 are checked against `phy_par[0]` and bits 15:8 against `phy_par[1]`. Either mismatch sets `cell_perr`.
- R9: An accepted qualified start-of-cell in the middle of a cell pulses `cell_abort` for one cycle. The interrupted cell gets no `cell_eop`, and counting restarts at 0 on the new start transfer.
- R10: Each delivered transfer appears on the cell port exactly one cycle after it was accepted, with `cell_data` equal to the sampled bus data.
- R11: While `rst_n` is low, `phy_enb_n` is high and `cell_valid`, `cell_sop`, `cell_eop` and `cell_abort` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_gate_soc | input | 1 | Require cell-available with start-of-cell |
| cfg_idle_off | input | 1 | Hold read enable inactive while waiting |
| cfg_extra_hdr | input | 1 | Drop one leading header transfer per cell |
| cfg_52 | input | 1 | 52-byte cells without HEC |
| cfg_par16 | input | 1 | 16-bit bus: parity over whole word |
| cfg_even_par | input | 1 | 1 = even parity, 0 = odd |
| phy_data | input | BUS_W | Receive data from PHY |
| phy_par | input | 2 | Receive parity bits |
| phy_soc | input | 1 | Start of cell |
| phy_clav | input | 1 | Cell available |
| phy_enb_n | output | 1 | Active-low read enable |
| cell_valid | output | 1 | Delivered transfer valid |
| cell_sop | output | 1 | First delivered transfer of a cell |
| cell_eop | output | 1 | Last transfer of a cell |
| cell_data | output | BUS_W | Delivered data |
| cell_perr | output | 1 | Parity error on this transfer |
| cell_hec | output | 1 | Cell carries a HEC byte |
| cell_abort | output | 1 | Previous cell cut short by a new start |

## Verification
The in-line assertions check on every cycle that the read enable is low when the idle option is off, and that it stays high while it waits for cell-available. They also check that a gated start without cell-available never opens a cell and that the counter stays inside the cell length. At the port they check that delivered transfers follow accepted ones, that end markers are followed only by idle or a fresh start, that a dropped header transfer is not delivered, and that the HEC flag matches the length mode. Only the bench scenarios can show the exact cycle of each end marker for every length and option combination, the parity verdict for each bit arrangement and polarity, and the restart count after an abort.

// File: rtl/cellrx_pkg.sv
package cellrx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_CELL = 2'd2
  } rx_state_t;

  // Transfers per cell for a length mode, header option and bytes per transfer.
  function automatic int unsigned cell_xfers(input logic is52, input logic extra,
                                             input int unsigned bpx);
    int unsigned bytes;
    bytes = is52 ? 32'd52 : 32'd53;
    return (bytes + bpx - 1) / bpx + (extra ? 32'd1 : 32'd0);
  endfunction

  // Parity mismatch from a reduction XOR of the data, the parity bit and polarity.
  function automatic logic par_bad(input logic red, input logic pbit, input logic even);
    return ~(red ^ pbit ^ even);
  endfunction

endpackage

// File: rtl/cellrx_parity.sv
module cellrx_parity
  import cellrx_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic [BUS_W-1:0] data,
  input  logic [1:0]       par,
  input  logic             cfg_par16,
  input  logic             cfg_even_par,
  output logic             perr
);

  generate
    if (BUS_W == 16) begin : g_wide
      logic err_word, err_lo, err_hi;
      assign err_word = par_bad(^data, par[1], cfg_even_par);
      assign err_lo   = par_bad(^data[7:0], par[0], cfg_even_par);
      assign err_hi   = par_bad(^data[15:8], par[1], cfg_even_par);
      assign perr     = cfg_par16 ? err_word : (err_lo | err_hi);
    end else begin : g_narrow
      logic sel_unused;
      assign sel_unused = cfg_par16 ^ par[0];
      assign perr       = par_bad(^data, par[1], cfg_even_par);
    end
  endgenerate

endmodule

// File: rtl/cellrx_seq.sv
module cellrx_seq
  import cellrx_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_gate_soc,
  input  logic cfg_idle_off,
  input  logic cfg_extra_hdr,
  input  logic cfg_52,
  input  logic phy_soc,
  input  logic phy_clav,
  output logic phy_enb_n,
  output logic xfer_fwd,
  output logic xfer_sop,
  output logic xfer_eop,
  output logic xfer_restart
);

  localparam int BPX   = BUS_W / 8;
  localparam int MAX_X = int'(cell_xfers(1'b0, 1'b1, BPX));
  localparam int CNT_W = $clog2(MAX_X + 1);

  rx_state_t        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, idx, total, hdr;
  logic             enb_n_q, accept, soc_ok, in_cell, beat, last;

  always_comb begin
    accept  = !enb_n_q;
    soc_ok  = accept && phy_soc && (!cfg_gate_soc || phy_clav);
    total   = CNT_W'(cell_xfers(cfg_52, cfg_extra_hdr, BPX));
    hdr     = CNT_W'(cfg_extra_hdr);
    in_cell = (state_q == ST_CELL);
    beat    = soc_ok || (in_cell && accept);
    idx     = soc_ok ? '0 : cnt_q + CNT_W'(1);
    last    = beat && (idx == total - CNT_W'(1));
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (soc_ok)                        state_d = ST_CELL;
        else if (cfg_idle_off && phy_clav) state_d = ST_HUNT;
      end
      ST_HUNT: begin
        if (soc_ok) state_d = ST_CELL;
      end
      default: begin
        if (last) state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      enb_n_q <= 1'b1;
    end else begin
      state_q <= state_d;
      if (beat) cnt_q <= idx;
      enb_n_q <= (state_d == ST_IDLE) && cfg_idle_off;
    end
  end

  assign phy_enb_n    = enb_n_q;
  assign xfer_fwd     = beat && (idx >= hdr);
  assign xfer_sop     = beat && (idx == hdr);
  assign xfer_eop     = last;
  assign xfer_restart = soc_ok && in_cell;

  // R3: inside a cell the stored index never reaches the last position
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_cell |-> (cnt_q < total - CNT_W'(1)));

  // R1: read enable active whenever the idle option is off
  assert_enb_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_idle_off |=> !phy_enb_n);

  // R1: parked read enable waits for cell-available
  assert_enb_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_enb_n && cfg_idle_off && !phy_clav) |=> phy_enb_n);

  // R2: gated start without cell-available never opens a cell
  assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_cell && cfg_gate_soc && !phy_clav) |=> (state_q != ST_CELL));

endmodule

// File: rtl/cellrx_out.sv
module cellrx_out #(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_fwd,
  input  logic             xfer_sop,
  input  logic             xfer_eop,
  input  logic             xfer_restart,
  input  logic             xfer_perr,
  input  logic             hec_on,
  input  logic [BUS_W-1:0] xfer_data,
  output logic             cell_valid,
  output logic             cell_sop,
  output logic             cell_eop,
  output logic [BUS_W-1:0] cell_data,
  output logic             cell_perr,
  output logic             cell_hec,
  output logic             cell_abort
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cell_valid <= 1'b0;
      cell_sop   <= 1'b0;
      cell_eop   <= 1'b0;
      cell_data  <= '0;
      cell_perr  <= 1'b0;
      cell_hec   <= 1'b0;
      cell_abort <= 1'b0;
    end else begin
      cell_valid <= xfer_fwd;
      cell_sop   <= xfer_fwd && xfer_sop;
      cell_eop   <= xfer_fwd && xfer_eop;
      cell_perr  <= xfer_fwd && xfer_perr;
      cell_hec   <= xfer_fwd && hec_on;
      cell_abort <= xfer_restart;
      if (xfer_fwd) cell_data <= xfer_data;
    end
  end

endmodule

// File: rtl/cellrx_front.sv
module cellrx_front
  import cellrx_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_gate_soc,
  input  logic             cfg_idle_off,
  input  logic             cfg_extra_hdr,
  input  logic             cfg_52,
  input  logic             cfg_par16,
  input  logic             cfg_even_par,
  input  logic [BUS_W-1:0] phy_data,
  input  logic [1:0]       phy_par,
  input  logic             phy_soc,
  input  logic             phy_clav,
  output logic             phy_enb_n,
  output logic             cell_valid,
  output logic             cell_sop,
  output logic             cell_eop,
  output logic [BUS_W-1:0] cell_data,
  output logic             cell_perr,
  output logic             cell_hec,
  output logic             cell_abort
);

  logic xfer_fwd, xfer_sop, xfer_eop, xfer_restart, xfer_perr;

  cellrx_parity #(.BUS_W(BUS_W)) parity_i (
    .data         (phy_data),
    .par          (phy_par),
    .cfg_par16    (cfg_par16),
    .cfg_even_par (cfg_even_par),
    .perr         (xfer_perr)
  );

  cellrx_seq #(.BUS_W(BUS_W)) seq_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_gate_soc  (cfg_gate_soc),
    .cfg_idle_off  (cfg_idle_off),
    .cfg_extra_hdr (cfg_extra_hdr),
    .cfg_52        (cfg_52),
    .phy_soc       (phy_soc),
    .phy_clav      (phy_clav),
    .phy_enb_n     (phy_enb_n),
    .xfer_fwd      (xfer_fwd),
    .xfer_sop      (xfer_sop),
    .xfer_eop      (xfer_eop),
    .xfer_restart  (xfer_restart)
  );

  cellrx_out #(.BUS_W(BUS_W)) out_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .xfer_fwd     (xfer_fwd),
    .xfer_sop     (xfer_sop),
    .xfer_eop     (xfer_eop),
    .xfer_restart (xfer_restart),
    .xfer_perr    (xfer_perr),
    .hec_on       (!cfg_52),
    .xfer_data    (phy_data),
    .cell_valid   (cell_valid),
    .cell_sop     (cell_sop),
    .cell_eop     (cell_eop),
    .cell_data    (cell_data),
    .cell_perr    (cell_perr),
    .cell_hec     (cell_hec),
    .cell_abort   (cell_abort)
  );

  // R3: an end marker always rides on a delivered transfer
  assert_eop_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cell_eop |-> cell_valid);

  // R3: after an end marker only idle or a fresh start may follow
  assert_after_eop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cell_eop |=> (!cell_valid || cell_sop));

  // R4: the start transfer is dropped when the extra header option is on
  assert_hdr_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!phy_enb_n && phy_soc && (!cfg_gate_soc || phy_clav) && cfg_extra_hdr) |=> !cell_valid);

  // R5: HEC flag follows the length mode
  assert_hec_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid |-> (cell_hec == !cfg_52));

  // R9: an abort never directly follows a completed cell
  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cell_abort |-> !$past(cell_eop));

  // R10: delivered transfers only follow an accepted bus cycle
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid |-> $past(!phy_enb_n));

endmodule

// File: tb/cellrx_front_tb.sv
`timescale 1ns/1ps
module cellrx_front_tb_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        cfg_gate_soc, cfg_idle_off, cfg_extra_hdr, cfg_52, cfg_par16, cfg_even_par;
  logic [15:0] phy_d16;
  logic [1:0]  phy_par;
  logic        phy_soc, phy_clav;

  logic        n_enb_n, n_valid, n_sop, n_eop, n_perr, n_hec, n_abort;
  logic [7:0]  n_data;
  logic        w_enb_n, w_valid, w_sop, w_eop, w_perr, w_hec, w_abort;
  logic [15:0] w_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  cellrx_front #(.BUS_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_gate_soc(cfg_gate_soc), .cfg_idle_off(cfg_idle_off),
    .cfg_extra_hdr(cfg_extra_hdr), .cfg_52(cfg_52), .cfg_par16(cfg_par16),
    .cfg_even_par(cfg_even_par), .phy_data(phy_d16[7:0]), .phy_par(phy_par),
    .phy_soc(phy_soc), .phy_clav(phy_clav), .phy_enb_n(n_enb_n), .cell_valid(n_valid),
    .cell_sop(n_sop), .cell_eop(n_eop), .cell_data(n_data), .cell_perr(n_perr),
    .cell_hec(n_hec), .cell_abort(n_abort));

  cellrx_front #(.BUS_W(16)) dut16_i (
    .clk(clk), .rst_n(rst_n), .cfg_gate_soc(cfg_gate_soc), .cfg_idle_off(cfg_idle_off),
    .cfg_extra_hdr(cfg_extra_hdr), .cfg_52(cfg_52), .cfg_par16(cfg_par16),
    .cfg_even_par(cfg_even_par), .phy_data(phy_d16), .phy_par(phy_par),
    .phy_soc(phy_soc), .phy_clav(phy_clav), .phy_enb_n(w_enb_n), .cell_valid(w_valid),
    .cell_sop(w_sop), .cell_eop(w_eop), .cell_data(w_data), .cell_perr(w_perr),
    .cell_hec(w_hec), .cell_abort(w_abort));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic good_par(input logic red, input logic even);
    return even ? red : ~red;
  endfunction

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(input logic soc, input logic clav, input logic [15:0] d, input logic [1:0] p);
    phy_soc = soc; phy_clav = clav; phy_d16 = d; phy_par = p;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    phy_soc = 1'b0; phy_clav = 1'b0; phy_d16 = '0; phy_par = '0;
    repeat (2) @(negedge clk);
    chk("R11", "reset enb_n", n_enb_n, 1);
    chk("R11", "reset valid", n_valid, 0);
    chk("R11", "reset sop/eop/abort", {n_sop, n_eop, n_abort}, 0);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 16'h0, 2'b00);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_gate_soc = 0; cfg_idle_off = 0; cfg_extra_hdr = 0; cfg_52 = 0;
    cfg_par16 = 1; cfg_even_par = 0;
    phy_soc = 0; phy_clav = 0; phy_d16 = '0; phy_par = '0;
    @(negedge clk);

    // 8-bit bus: sweep every combination of the five cell options
    for (int c = 0; c < 32; c++) begin
      int n, k, prefix;
      cfg_52 = c[0]; cfg_extra_hdr = c[1]; cfg_even_par = c[2];
      cfg_gate_soc = c[3]; cfg_idle_off = c[4]; cfg_par16 = c[2];
      do_reset();
      chk("R1", "enb_n while waiting", n_enb_n, int'(cfg_idle_off));
      if (cfg_idle_off) begin
        step(1'b0, 1'b1, 16'h0, 2'b00);
        chk("R1", "enb_n after clav", n_enb_n, 0);
      end
      if (cfg_gate_soc) begin
        step(1'b1, 1'b0, 16'h005A, 2'b00);
        chk("R2", "gated soc without clav", n_valid, 0);
      end
      n      = (cfg_52 ? 52 : 53) + int'(cfg_extra_hdr);
      k      = (c * 7 + 3) % n;
      prefix = (c % 3 == 1) ? 5 : 0;
      for (int i = 0; i < prefix; i++) begin
        logic [7:0] d;
        d = 8'((i * 29 + c + 100) & 255);
        step(i == 0, (i == 0) ? cfg_gate_soc : 1'b1, {8'h00, d},
             {good_par(^d, cfg_even_par), 1'b0});
        chk("R4", "prefix valid", n_valid, int'(!(cfg_extra_hdr && i == 0)));
        chk("R9", "prefix no eop", n_eop, 0);
      end
      for (int i = 0; i < n; i++) begin
        logic [7:0] d;
        logic       fw;
        d  = 8'((i * 13 + c) & 255);
        fw = !(cfg_extra_hdr && i == 0);
        step(i == 0, (i == 0) ? cfg_gate_soc : 1'b1, {8'hA5, d},
             {good_par(^d, cfg_even_par) ^ (i == k), 1'(i & 1)});
        chk("R4", "valid", n_valid, int'(fw));
        chk("R9", "abort", n_abort, int'(i == 0 && prefix > 0));
        if (fw) begin
          chk("R4", "sop", n_sop, int'(i == int'(cfg_extra_hdr)));
          chk("R3", "eop", n_eop, int'(i == n - 1));
          chk("R10", "data", n_data, d);
          chk("R6", "perr", n_perr, int'(i == k));
          chk("R5", "hec", n_hec, int'(!cfg_52));
        end
      end
      chk("R1", "enb_n after eop", n_enb_n, int'(cfg_idle_off));
      step(1'b0, 1'b0, 16'h0, 2'b00);
      chk("R3", "idle after cell", n_valid, 0);
    end

    // 16-bit bus: length modes, header option, polarity and parity coverage
    for (int c = 0; c < 16; c++) begin
      int n, k;
      cfg_52 = c[0]; cfg_extra_hdr = c[1]; cfg_even_par = c[2]; cfg_par16 = c[3];
      cfg_gate_soc = 0; cfg_idle_off = 0;
      do_reset();
      n = ((cfg_52 ? 52 : 53) + 1) / 2 + int'(cfg_extra_hdr);
      k = (c * 5 + 2) % n;
      for (int i = 0; i < n; i++) begin
        logic [7:0] lo, hi;
        logic [1:0] p;
        logic       fw;
        lo = 8'((i * 5 + c) & 255);
        hi = 8'((i * 11 + 1) & 255);
        if (cfg_par16) p = {good_par(^{hi, lo}, cfg_even_par) ^ (i == k), 1'(i & 1)};
        else           p = {good_par(^hi, cfg_even_par) ^ (i == k && k % 2 == 0),
                            good_par(^lo, cfg_even_par) ^ (i == k && k % 2 == 1)};
        fw = !(cfg_extra_hdr && i == 0);
        step(i == 0, 1'b1, {hi, lo}, p);
        chk("R3", "wide valid", w_valid, int'(fw));
        if (fw) begin
          chk("R4", "wide sop", w_sop, int'(i == int'(cfg_extra_hdr)));
          chk("R3", "wide eop", w_eop, int'(i == n - 1));
          chk("R10", "wide data", w_data, {hi, lo});
          if (cfg_par16) chk("R7", "wide word perr", w_perr, int'(i == k));
          else           chk("R8", "wide byte perr", w_perr, int'(i == k));
          chk("R5", "wide hec", w_hec, int'(!cfg_52));
        end
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule